// File: doc/BRIEF.md
# Down-Counting Interval Timer with Register Interface

This block is a 32-bit interval timer that sits on a simple word-addressed register bus. Software sets a reload value, selects one-shot or repeating operation, and starts or halts the count with separate command bits. The counter decrements by one every clock while running. On reaching zero it raises a sticky expiry flag and reloads. An interrupt line follows that flag when it is enabled.

The reload value and the captured count are both 32 bits wide but are reached as two 16-bit halves. A read of the live count would tear between the two halves, so software first writes a capture register. That write freezes the whole current count into a holding register, and both halves are then read at leisure. Software that wants a rising timebase inverts the captured value.

Top module: `ivt_top`

## Requirements
- R1: After reset the status word reads 0, the control word reads 0, both reload halves read 0x0000FFFF, both capture halves read 0, and `irq_o` is low.
- R2: Word 2 holds reload bits 15:0 and word 3 holds reload bits 31:16, each in data bits 15:0 with bits 31:16 reading 0. A write to either half loads the counter with the new full reload value and clears the running state in that cycle.
- R3: While running, the count drops by exactly one per clock when it is not zero. While stopped, it holds its value.
- R4: A running count of zero sets the expiry flag and reloads the counter from the reload value on the next edge. In repeating mode counting goes on. In one-shot mode the timer stops unless a start command arrives in that same cycle.
- R5: In control word 1, bit 0 is interrupt enable, bit 1 is repeating mode, bit 2 is start and bit 3 is stop. When start and stop are written together, stop wins. Bits 0 and 1 read back as written, and bits 2 and 3 always read 0. A control write does not change the count.
- R6: Any write to word 4 copies the count held before that edge into the capture register, so word 4 returns bits 15:0 and word 5 returns bits 31:16, and that value stays frozen. A write to word 5 has no effect.
- R7: In status word 0, bit 0 is the expiry flag and bit 1 reads 1 while the timer runs. Any write to word 0 clears the expiry flag, except that an expiry in the same cycle keeps it set.
- R8: `irq_o` is high exactly when the expiry flag and interrupt enable are both set.
- R9: Word indices 6 and 7 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus inputs never carry unknown values after reset. They also assume at most one access per cycle, with `bus_we` meaningful only when `bus_sel` is high. The bench drives each access for exactly one clock from its own tasks, returns `bus_sel` low between accesses, and holds every input at a defined value from time zero. Random reload values are kept small, so that expiry, one-shot stop and reload happen often inside the run.

// File: rtl/ivt_pkg.sv
// Package: shared register indices, control bit positions and sizes for the
// interval timer. Assumes a word-addressed bus with one register per index.
package ivt_pkg;
    localparam int IVT_NUM_REGS = 6;

    localparam int IDX_STATUS  = 0;
    localparam int IDX_CONTROL = 1;
    localparam int IDX_PER_LO  = 2;
    localparam int IDX_PER_HI  = 3;
    localparam int IDX_SNAP_LO = 4;
    localparam int IDX_SNAP_HI = 5;

    localparam int CB_IRQ_EN = 0;
    localparam int CB_REPEAT = 1;
    localparam int CB_START  = 2;
    localparam int CB_STOP   = 3;

    localparam int SB_EXPIRED = 0;
    localparam int SB_RUNNING = 1;
endpackage

// File: rtl/ivt_bus_decode.sv
// Bus decode: turns one access per cycle into per-register write strobes and
// selects the read word. Assumes bus_we is only meaningful with bus_sel.
// Indices at or above NUM_REGS read zero and raise no strobe.
module ivt_bus_decode #(
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 6
) (
    input  logic                             bus_sel,
    input  logic                             bus_we,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  rd_words,
    output logic [NUM_REGS-1:0]              wr_stb,
    output logic [DATA_W-1:0]                bus_rdata
);
    // One strobe per register index
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_stb
        assign wr_stb[gi] = bus_sel && bus_we && (bus_addr == ADDR_W'(gi));
    end

    // Read multiplexer; unmapped indices return zero
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (bus_addr == ADDR_W'(i)) begin
                bus_rdata = rd_words[i];
            end
        end
    end
endmodule

// File: rtl/ivt_ctrl_regs.sv
// Control and reload registers. Holds interrupt enable, repeat mode and the
// reload value as two halves. Produces start and stop pulses for the counter
// and a period-write pulse together with the reload value about to be stored.
// Assumes at most one write strobe is active per cycle.
module ivt_ctrl_regs #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              per_lo_wr,
    input  logic              per_hi_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              irq_en_q,
    output logic              repeat_q,
    output logic              start_cmd,
    output logic              stop_cmd,
    output logic              per_wr,
    output logic [CNT_W-1:0]  period_q,
    output logic [CNT_W-1:0]  period_nxt
);
    import ivt_pkg::*;

    localparam int HALF_W = CNT_W / 2;

    logic [1:0]            half_wr;
    logic [1:0][HALF_W-1:0] half_q;
    logic [1:0][HALF_W-1:0] half_nxt;

    assign half_wr = {per_hi_wr, per_lo_wr};

    // Each reload half takes the low bits of the write data on its strobe
    for (genvar gh = 0; gh < 2; gh++) begin : g_half
        assign half_nxt[gh] = half_wr[gh] ? wdata[HALF_W-1:0] : half_q[gh];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q[gh] <= '1;
            end else begin
                half_q[gh] <= half_nxt[gh];
            end
        end
    end

    assign period_q   = {half_q[1], half_q[0]};
    assign period_nxt = {half_nxt[1], half_nxt[0]};
    assign per_wr     = |half_wr;

    // Mode bits update on any control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
            repeat_q <= 1'b0;
        end else if (ctrl_wr) begin
            irq_en_q <= wdata[CB_IRQ_EN];
            repeat_q <= wdata[CB_REPEAT];
        end
    end

    // Command pulses exist only in the write cycle; stop outranks start
    assign stop_cmd  = ctrl_wr && wdata[CB_STOP];
    assign start_cmd = ctrl_wr && wdata[CB_START] && !wdata[CB_STOP];

    logic unused_wdata;
    assign unused_wdata = ^{wdata[DATA_W-1:HALF_W]};
endmodule

// File: rtl/ivt_counter.sv
// Down counter with run control and sticky expiry flag. Decrements while
// running, reloads from the period at zero, stops at zero in one-shot mode.
// A period write reloads the count and halts. Assumes the command pulses come
// from ivt_ctrl_regs, where stop already outranks start.
module ivt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] period_q,
    input  logic [CNT_W-1:0] period_nxt,
    input  logic             repeat_q,
    input  logic             start_cmd,
    input  logic             stop_cmd,
    input  logic             stat_wr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_q,
    output logic             expired_q,
    output logic             expire_evt
);
    logic at_zero;

    assign at_zero    = (cnt_q == '0);
    assign expire_evt = run_q && at_zero && !per_wr;

    // Count register: reload on period write or expiry, else step down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (per_wr) begin
            cnt_q <= period_nxt;
        end else if (run_q) begin
            cnt_q <= at_zero ? period_q : cnt_q - 1'b1;
        end
    end

    // Run state: period write and stop halt, start runs, one-shot ends at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (per_wr || stop_cmd) begin
            run_q <= 1'b0;
        end else if (start_cmd) begin
            run_q <= 1'b1;
        end else if (expire_evt && !repeat_q) begin
            run_q <= 1'b0;
        end
    end

    // Expiry flag: set by expiry, cleared by a status write, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expired_q <= 1'b0;
        end else if (expire_evt) begin
            expired_q <= 1'b1;
        end else if (stat_wr) begin
            expired_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ivt_snapshot.sv
// Capture register: a strobe copies the full count in one edge so the two
// halves read back coherently. Assumes the strobe lasts one cycle per access.
module ivt_snapshot #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_stb,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] snap_q
);
    // Hold the captured count until the next strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (cap_stb) begin
            snap_q <= cnt_q;
        end
    end
endmodule

// File: rtl/ivt_top.sv
// Interval timer top: wires bus decode, control registers, down counter and
// capture register, and forms the read words and the interrupt. Assumes one
// bus access per cycle and CNT_W equal to twice the register half width.
module ivt_top #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    import ivt_pkg::*;

    localparam int HALF_W = CNT_W / 2;
    localparam int NREG   = IVT_NUM_REGS;

    logic [NREG-1:0]             wr_stb;
    logic [NREG-1:0][DATA_W-1:0] rd_words;
    logic                        irq_en_q;
    logic                        repeat_q;
    logic                        start_cmd;
    logic                        stop_cmd;
    logic                        per_wr;
    logic [CNT_W-1:0]            period_q;
    logic [CNT_W-1:0]            period_nxt;
    logic [CNT_W-1:0]            cnt_q;
    logic                        run_q;
    logic                        expired_q;
    logic                        expire_evt;
    logic [CNT_W-1:0]            snap_q;

    ivt_bus_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NREG)
    ) u_dec (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .rd_words  (rd_words),
        .wr_stb    (wr_stb),
        .bus_rdata (bus_rdata)
    );

    ivt_ctrl_regs #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_stb[IDX_CONTROL]),
        .per_lo_wr  (wr_stb[IDX_PER_LO]),
        .per_hi_wr  (wr_stb[IDX_PER_HI]),
        .wdata      (bus_wdata),
        .irq_en_q   (irq_en_q),
        .repeat_q   (repeat_q),
        .start_cmd  (start_cmd),
        .stop_cmd   (stop_cmd),
        .per_wr     (per_wr),
        .period_q   (period_q),
        .period_nxt (period_nxt)
    );

    ivt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_wr     (per_wr),
        .period_q   (period_q),
        .period_nxt (period_nxt),
        .repeat_q   (repeat_q),
        .start_cmd  (start_cmd),
        .stop_cmd   (stop_cmd),
        .stat_wr    (wr_stb[IDX_STATUS]),
        .cnt_q      (cnt_q),
        .run_q      (run_q),
        .expired_q  (expired_q),
        .expire_evt (expire_evt)
    );

    ivt_snapshot #(
        .CNT_W (CNT_W)
    ) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_stb (wr_stb[IDX_SNAP_LO]),
        .cnt_q   (cnt_q),
        .snap_q  (snap_q)
    );

    // Assemble the read words; halves sit in the low bits of each word
    always_comb begin
        rd_words = '0;
        rd_words[IDX_STATUS][SB_EXPIRED] = expired_q;
        rd_words[IDX_STATUS][SB_RUNNING] = run_q;
        rd_words[IDX_CONTROL][CB_IRQ_EN] = irq_en_q;
        rd_words[IDX_CONTROL][CB_REPEAT] = repeat_q;
        rd_words[IDX_PER_LO][HALF_W-1:0] = period_q[HALF_W-1:0];
        rd_words[IDX_PER_HI][HALF_W-1:0] = period_q[CNT_W-1:HALF_W];
        rd_words[IDX_SNAP_LO][HALF_W-1:0] = snap_q[HALF_W-1:0];
        rd_words[IDX_SNAP_HI][HALF_W-1:0] = snap_q[CNT_W-1:HALF_W];
    end

    // Interrupt follows the expiry flag when enabled
    assign irq_o = expired_q && irq_en_q;

    logic unused_stb;
    assign unused_stb = ^{wr_stb[IDX_SNAP_HI], expire_evt};
endmodule

// File: rtl/ivt_checker.sv
// Checker for ivt_top: properties over bus ports and counter state.
// Assumes inputs are known after reset and one access per cycle.
module ivt_checker #(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  period_q,
    input logic              run_q,
    input logic              expired_q,
    input logic              irq_en_q
);
    logic wr_any;
    logic wr_per;
    logic wr_ctl;
    logic wr_stat;

    assign wr_any  = bus_sel && bus_we;
    assign wr_per  = wr_any && (bus_addr == ADDR_W'(2) || bus_addr == ADDR_W'(3));
    assign wr_ctl  = wr_any && (bus_addr == ADDR_W'(1));
    assign wr_stat = wr_any && (bus_addr == ADDR_W'(0));

    a_in_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({bus_sel, bus_we, bus_addr}));

    a_r2_per_write_halts: assert property (@(posedge clk) disable iff (!rst_n)
        wr_per |=> !run_q);

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0 && !wr_per) |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_per) |=> $stable(cnt_q));

    a_r4_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == '0 && !wr_per) |=> expired_q);

    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == '0 && !wr_per) |=> (cnt_q == $past(period_q)));

    a_r5_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && bus_wdata[3]) |=> !run_q);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !(run_q && cnt_q == '0)) |=> !expired_q);

    a_r8_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en_q && expired_q));
endmodule

bind ivt_top ivt_checker #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .cnt_q     (cnt_q),
    .period_q  (period_q),
    .run_q     (run_q),
    .expired_q (expired_q),
    .irq_en_q  (irq_en_q)
);

// File: tb/ivt_top_tb.sv
// Bench for ivt_top: a behavioural model built from the requirements tracks
// expected state; directed corner cases and seeded random traffic follow.
module ivt_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ivt_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // Reference state
    logic [31:0] m_cnt, m_per, m_snap;
    logic        m_run, m_exp, m_ie, m_rep;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '1; m_per <= '1; m_snap <= '0;
            m_run <= 0; m_exp <= 0; m_ie <= 0; m_rep <= 0;
        end else begin
            logic        w;
            logic [31:0] np;
            logic        evt;
            w   = bus_sel && bus_we;
            np  = m_per;
            if (w && bus_addr == 3'd2) np[15:0]  = bus_wdata[15:0];
            if (w && bus_addr == 3'd3) np[31:16] = bus_wdata[15:0];
            evt = m_run && m_cnt == 0 && !(w && (bus_addr == 3'd2 || bus_addr == 3'd3));
            m_per <= np;
            if (w && (bus_addr == 3'd2 || bus_addr == 3'd3)) begin
                m_cnt <= np; m_run <= 0;
            end else begin
                if (m_run) m_cnt <= (m_cnt == 0) ? m_per : m_cnt - 1;
                if (w && bus_addr == 3'd1 && bus_wdata[3]) m_run <= 0;
                else if (w && bus_addr == 3'd1 && bus_wdata[2]) m_run <= 1;
                else if (evt && !m_rep) m_run <= 0;
            end
            if (w && bus_addr == 3'd1) begin
                m_ie <= bus_wdata[0]; m_rep <= bus_wdata[1];
            end
            if (evt) m_exp <= 1;
            else if (w && bus_addr == 3'd0) m_exp <= 0;
            if (w && bus_addr == 3'd4) m_snap <= m_cnt;
        end
    end

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return {30'd0, m_run, m_exp};
            3'd1:    return {30'd0, m_rep, m_ie};
            3'd2:    return {16'd0, m_per[15:0]};
            3'd3:    return {16'd0, m_per[31:16]};
            3'd4:    return {16'd0, m_snap[15:0]};
            3'd5:    return {16'd0, m_snap[31:16]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0:       return "R7";
            3'd1:       return "R5";
            3'd2, 3'd3: return "R2";
            3'd4, 3'd5: return "R6";
            default:    return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
        n_cmp++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, expv, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_read(a));
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R8: interrupt compared every cycle after reset
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #2;
            check("R8", {31'd0, irq_o}, {31'd0, m_ie && m_exp});
        end
    end

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values of every word and irq
        for (int a = 0; a < 6; a++) begin
            @(negedge clk);
            bus_addr = 3'(a);
            #1;
            check("R1", bus_rdata, (a == 2 || a == 3) ? 32'h0000_FFFF : 32'd0);
        end
        check("R1", {31'd0, irq_o}, 32'd0);

        // R2: halves land in their own bit ranges, upper bits ignored
        wr(3'd2, 32'hABCD_0006);
        wr(3'd3, 32'h1234_0000);
        rd(3'd2, "R2"); rd(3'd3, "R2");
        rd(3'd0, "R2");

        // R3: one-shot start, decrement then capture
        wr(3'd1, 32'h0000_0005);
        idle(2);
        wr(3'd4, 32'h0);
        rd(3'd4, "R3"); rd(3'd5, "R3");
        // R4: one-shot expiry stops and sets the flag
        idle(10);
        rd(3'd0, "R4");
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, "R4");
        // R7: clearing the flag
        wr(3'd0, 32'h0);
        rd(3'd0, "R7");

        // R5: start and stop together, stop wins; command bits read 0
        wr(3'd1, 32'h0000_000F);
        rd(3'd1, "R5"); rd(3'd0, "R5");

        // R4: repeating mode keeps running across wraps
        wr(3'd2, 32'h0000_0003);
        wr(3'd3, 32'h0);
        wr(3'd1, 32'h0000_0007);
        idle(11);
        rd(3'd0, "R4");
        wr(3'd4, 32'h0);
        rd(3'd4, "R4");

        // R6: write to upper capture half has no effect
        wr(3'd5, 32'h0000_5A5A);
        rd(3'd5, "R6"); rd(3'd4, "R6");

        // R9: unmapped indices read zero, writes change nothing
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd6, "R9"); rd(3'd7, "R9"); rd(3'd1, "R9");

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = int'($urandom % 10);
            case (op)
                0: wr(3'd1, $urandom & 32'hF);
                1: wr(3'd2, $urandom % 24);
                2: wr(3'd3, ($urandom % 8 == 0) ? 32'h1 : 32'h0);
                3: wr(3'd0, $urandom);
                4: wr(3'd4, $urandom);
                5: wr(3'($urandom % 8), $urandom);
                6: idle(int'($urandom % 6));
                default: begin
                    logic [2:0] a;
                    a = 3'($urandom % 8);
                    rd(a, tag_of(a));
                end
            endcase
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule